// File: doc/BRIEF.md
# Stacked Picture-in-Picture Window Overlay Selector

This block classifies every pixel of the output raster while it is being scanned. For each pixel it decides whether the main picture should show, or whether a small inset window covers it. A covered pixel can take a window frame colour, the window's live or stored image, forced black, or a flat colour fill. Up to four inset windows at 1/16 screen area, or up to three at 1/9 area, are stacked one directly under another. The whole stack moves across the screen in 64 coarse steps on each axis.

The raster counters come in from the display timing chain. The configuration inputs come straight from the control registers. The outputs are a one-cycle-late verdict for the pixel: an overlay flag, a source code, the number of the window hit, and a flag that marks the window carrying live video. Downstream logic uses these to choose the memory read, the frame colour or the fill colour, and to steer the video multiplexer.

Top module: `pip_overlay_gen`

## Requirements
- R1: With `size_big`=0 each window image is 84 pixels by 53 lines, and with `size_big`=1 it is 114 by 71. Each image has a frame 3 pixels wide at left and right and 2 lines at top and bottom. Framed windows are stacked without gaps, downward from the stack origin. There are 4 slots in small mode and 3 in large mode.
- R2: The stack origin is `xpos`*(H_ACTIVE/64) horizontally and `ypos`*(V_ACTIVE/64) vertically. Each coordinate is clamped so that the full framed stack fits inside the active area. A pixel with `hcnt` >= H_ACTIVE or `vcnt` >= V_ACTIVE is never overlaid.
- R3: Bit i of `win_on` enables slot i, counted from the top (bit 0 is the top slot). A pixel outside every enabled slot gives `ovl_active`=0, `src_sel`=0 (main), `win_idx`=0 and `live`=0. The source codes are 0 main, 1 frame, 2 image, 3 black and 4 fill.
- R4: In large mode, bit 3 of `win_on` and bit 3 of `win_blank` both act on the third slot, as does `live_sel`=3. `win_idx` never reads 4 in large mode.
- R5: `border_code` values 010 and 011 make the frame transparent, so frame pixels show as main picture (`ovl_active`=0). Every other code gives frame pixels `src_sel`=1.
- R6: A set `win_blank` bit forces the image area of its window to `src_sel`=3. This holds even when the window is newly enabled, and it takes priority over fill. The frame is still drawn.
- R7: A non-zero `fill_code` (01, 10 or 11) gives the image area of unblanked windows `src_sel`=4. `fill_code`=00 gives `src_sel`=2.
- R8: While `ovl_active`=1, `win_idx` holds the slot number from 1 at the top. `live`=1 only on image-area pixels of the enabled window chosen by `live_sel` (0 is the top slot).
- R9: All outputs are registered one clock after the counters that produce them. While `rst_n` is low the outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hcnt | input | HW | Horizontal pixel counter |
| vcnt | input | VW | Vertical line counter |
| size_big | input | 1 | 0 = 1/16 windows, 1 = 1/9 windows |
| xpos | input | 6 | Horizontal stack position code |
| ypos | input | 6 | Vertical stack position code |
| win_on | input | 4 | Per-slot enable, bit 0 at top |
| win_blank | input | 4 | Per-slot force-to-black |
| border_code | input | 3 | Frame colour code |
| fill_code | input | 2 | Solid fill select |
| live_sel | input | 2 | Slot carrying live video |
| ovl_active | output | 1 | Pixel covered by an inset |
| src_sel | output | 3 | Source code for the pixel |
| win_idx | output | 3 | Window number hit, 0 when none |
| live | output | 1 | Pixel in live window image |

## Verification
The hardest case to reach is the large-mode stack with only the fourth mask bits set and live select at 3. Here the third slot must light up, be blanked and be flagged live, even though no bit names it directly. The bench drives this configuration on purpose and probes the frame/image edges of every slot. It also probes with both position codes at 63, which exercises the clamp so that the last slot's bottom frame line lands on the final active line. Full-raster sweeps at a coarse stride then compare every sampled pixel against an independent division-based model.

// File: rtl/pip_overlay_gen.sv
module pip_overlay_gen #(
  parameter int H_ACTIVE = 640,
  parameter int V_ACTIVE = 240,
  parameter int HW = 10,
  parameter int VW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] hcnt,
  input  logic [VW-1:0] vcnt,
  input  logic          size_big,
  input  logic [5:0]    xpos,
  input  logic [5:0]    ypos,
  input  logic [3:0]    win_on,
  input  logic [3:0]    win_blank,
  input  logic [2:0]    border_code,
  input  logic [1:0]    fill_code,
  input  logic [1:0]    live_sel,
  output logic          ovl_active,
  output logic [2:0]    src_sel,
  output logic [2:0]    win_idx,
  output logic          live
);
  localparam logic [31:0] SW  = 32'd84;
  localparam logic [31:0] SH  = 32'd53;
  localparam logic [31:0] LW  = 32'd114;
  localparam logic [31:0] LH  = 32'd71;
  localparam logic [31:0] BX  = 32'd3;
  localparam logic [31:0] BY  = 32'd2;
  localparam logic [31:0] HA  = 32'(H_ACTIVE);
  localparam logic [31:0] VA  = 32'(V_ACTIVE);
  localparam logic [31:0] STX = 32'(H_ACTIVE / 64);
  localparam logic [31:0] STY = 32'(V_ACTIVE / 64);

  localparam logic [2:0] SRC_MAIN  = 3'd0;
  localparam logic [2:0] SRC_FRAME = 3'd1;
  localparam logic [2:0] SRC_IMAGE = 3'd2;
  localparam logic [2:0] SRC_BLACK = 3'd3;
  localparam logic [2:0] SRC_FILL  = 3'd4;

  logic [31:0] hx, vy, ww, wh, fw, fh, stk, xr, yr, x0, y0, dx, dy, ly;
  logic [1:0]  slot, live_m;
  logic [3:0]  on_m, bl_m;
  logic        in_fr, img, shown, clear;
  logic        act_n, live_n;
  logic [2:0]  src_n, idx_n;

  assign hx  = {{(32-HW){1'b0}}, hcnt};
  assign vy  = {{(32-VW){1'b0}}, vcnt};
  assign ww  = size_big ? LW : SW;
  assign wh  = size_big ? LH : SH;
  assign fw  = ww + 2 * BX;
  assign fh  = wh + 2 * BY;
  assign stk = size_big ? 3 * fh : 4 * fh;
  assign xr  = {26'd0, xpos} * STX;
  assign yr  = {26'd0, ypos} * STY;
  assign x0  = (xr > HA - fw) ? HA - fw : xr;
  assign y0  = (yr > VA - stk) ? VA - stk : yr;
  assign dx  = hx - x0;
  assign dy  = vy - y0;
  assign in_fr = hx >= x0 && hx < x0 + fw && vy >= y0 && vy < y0 + stk;

  always_comb begin
    slot = 2'd0;
    ly   = dy;
    for (int i = 1; i < 4; i++) begin
      if (dy >= 32'(i) * fh) begin
        slot = 2'(i);
        ly   = dy - 32'(i) * fh;
      end
    end
  end

  assign on_m   = size_big ? {1'b0, win_on[3] | win_on[2], win_on[1:0]} : win_on;
  assign bl_m   = size_big ? {1'b0, win_blank[3] | win_blank[2], win_blank[1:0]} : win_blank;
  assign live_m = (size_big && live_sel == 2'd3) ? 2'd2 : live_sel;
  assign img    = dx >= BX && dx < BX + ww && ly >= BY && ly < BY + wh;
  assign shown  = in_fr && on_m[slot];
  assign clear  = border_code[2:1] == 2'b01;

  always_comb begin
    src_n = SRC_MAIN;
    if (shown) begin
      if (!img)              src_n = clear ? SRC_MAIN : SRC_FRAME;
      else if (bl_m[slot])   src_n = SRC_BLACK;
      else if (fill_code != 2'd0) src_n = SRC_FILL;
      else                   src_n = SRC_IMAGE;
    end
    act_n  = src_n != SRC_MAIN;
    idx_n  = act_n ? {1'b0, slot} + 3'd1 : 3'd0;
    live_n = shown && img && slot == live_m;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovl_active <= 1'b0;
      src_sel    <= SRC_MAIN;
      win_idx    <= 3'd0;
      live       <= 1'b0;
    end else begin
      ovl_active <= act_n;
      src_sel    <= src_n;
      win_idx    <= idx_n;
      live       <= live_n;
    end
  end
endmodule

// File: rtl/pip_overlay_chk.sv
module pip_overlay_chk #(
  parameter int H_ACTIVE = 640,
  parameter int HW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic [HW-1:0] hcnt,
  input logic          size_big,
  input logic [3:0]    win_on,
  input logic [3:0]    win_blank,
  input logic          ovl_active,
  input logic [2:0]    src_sel,
  input logic [2:0]    win_idx,
  input logic          live
);
  localparam logic [HW:0] HA_W = (HW+1)'(H_ACTIVE);

  logic [3:0]    prev_on, prev_blank;
  logic          prev_big;
  logic [HW-1:0] prev_h;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_on <= '0; prev_blank <= '0; prev_big <= 1'b0; prev_h <= '0;
    end else begin
      prev_on <= win_on; prev_blank <= win_blank; prev_big <= size_big; prev_h <= hcnt;
    end
  end

  assert_idle_main_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ovl_active |-> (src_sel == 3'd0 && win_idx == 3'd0 && !live));

  assert_slot_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_active && !prev_big) |-> (win_idx != 3'd0 && prev_on[2'(win_idx - 3'd1)]));

  assert_big_third_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_active && prev_big) |-> (win_idx != 3'd0 && win_idx != 3'd4 &&
      (win_idx != 3'd3 || prev_on[2] || prev_on[3])));

  assert_black_blanked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 3'd3 && !prev_big) |-> prev_blank[2'(win_idx - 3'd1)]);

  assert_sync_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, prev_h} >= HA_W) |-> !ovl_active);

  assert_live_image_R8: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (src_sel == 3'd2 || src_sel == 3'd3 || src_sel == 3'd4));
endmodule

bind pip_overlay_gen pip_overlay_chk #(.H_ACTIVE(H_ACTIVE), .HW(HW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .size_big(size_big),
  .win_on(win_on), .win_blank(win_blank), .ovl_active(ovl_active),
  .src_sel(src_sel), .win_idx(win_idx), .live(live));

// File: tb/pip_overlay_gen_bench.sv
module pip_overlay_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HA = 640;
  localparam int VA = 240;
  localparam int HW = 10;
  localparam int VW = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [HW-1:0] hcnt = '0;
  logic [VW-1:0] vcnt = '0;
  logic size_big = 1'b0;
  logic [5:0] xpos = 6'd10, ypos = 6'd2;
  logic [3:0] win_on = 4'hF, win_blank = 4'h0;
  logic [2:0] border_code = 3'd0;
  logic [1:0] fill_code = 2'd0, live_sel = 2'd0;
  logic ovl_active, live;
  logic [2:0] src_sel, win_idx;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pip_overlay_gen #(.H_ACTIVE(HA), .V_ACTIVE(VA), .HW(HW), .VW(VW)) u_pip_overlay_gen (
    .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt), .size_big(size_big),
    .xpos(xpos), .ypos(ypos), .win_on(win_on), .win_blank(win_blank),
    .border_code(border_code), .fill_code(fill_code), .live_sel(live_sel),
    .ovl_active(ovl_active), .src_sel(src_sel), .win_idx(win_idx), .live(live));

  // expected {active, src[2:0], idx[2:0], live}
  function automatic logic [7:0] model(int h, int v);
    int w, hh, fw, fh, n, x0, y0, s, lx, ly, lv;
    bit onb, blb, isimg;
    logic [2:0] src;
    w  = size_big ? 114 : 84;
    hh = size_big ? 71 : 53;
    fw = w + 6; fh = hh + 4; n = size_big ? 3 : 4;
    x0 = int'(xpos) * (HA / 64); if (x0 > HA - fw) x0 = HA - fw;
    y0 = int'(ypos) * (VA / 64); if (y0 > VA - n * fh) y0 = VA - n * fh;
    if (h < x0 || h >= x0 + fw || v < y0 || v >= y0 + n * fh) return 8'd0;
    s = (v - y0) / fh; ly = (v - y0) % fh; lx = h - x0;
    onb = win_on[s] || (size_big && s == 2 && win_on[3]);
    blb = win_blank[s] || (size_big && s == 2 && win_blank[3]);
    lv  = (size_big && live_sel == 2'd3) ? 2 : int'(live_sel);
    if (!onb) return 8'd0;
    isimg = lx >= 3 && lx < 3 + w && ly >= 2 && ly < 2 + hh;
    if (!isimg) begin
      if (border_code == 3'd2 || border_code == 3'd3) return 8'd0;
      return {1'b1, 3'd1, 3'(s + 1), 1'b0};
    end
    src = blb ? 3'd3 : (fill_code != 2'd0 ? 3'd4 : 3'd2);
    return {1'b1, src, 3'(s + 1), s == lv};
  endfunction

  task automatic drive(int h, int v, string tag);
    @(negedge clk);
    hcnt = h[HW-1:0];
    vcnt = v[VW-1:0];
    exp_q.push_back(model(h, v));
    tag_q.push_back(tag);
  endtask

  task automatic cfg(bit big, int x, int y, logic [3:0] on, logic [3:0] bl,
                     logic [2:0] bc, logic [1:0] fl, logic [1:0] ls);
    @(negedge clk);
    size_big = big; xpos = 6'(x); ypos = 6'(y); win_on = on; win_blank = bl;
    border_code = bc; fill_code = fl; live_sel = ls;
  endtask

  task automatic probe(string tag);
    int w, hh, fw, fh, n, x0, y0;
    int dxs[8], dys[8];
    w  = size_big ? 114 : 84;  hh = size_big ? 71 : 53;
    fw = w + 6; fh = hh + 4; n = size_big ? 3 : 4;
    x0 = int'(xpos) * (HA / 64); if (x0 > HA - fw) x0 = HA - fw;
    y0 = int'(ypos) * (VA / 64); if (y0 > VA - n * fh) y0 = VA - n * fh;
    dxs = '{-1, 0, 2, 3, w + 2, w + 3, w + 5, w + 6};
    dys = '{-1, 0, 1, 2, hh + 1, hh + 2, hh + 3, hh + 4};
    for (int s = 0; s < n; s++)
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++)
          if (x0 + dxs[a] >= 0 && y0 + s * fh + dys[b] >= 0 && y0 + s * fh + dys[b] < 512)
            drive(x0 + dxs[a], y0 + s * fh + dys[b], tag);
  endtask

  task automatic sweep(string tag);
    for (int v = 0; v < VA; v += 2)
      for (int h = 0; h < HA; h += 5)
        drive(h, v, tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [7:0] e, a;
      string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      a = {ovl_active, src_sel, win_idx, live};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s h=%0d v=%0d act/src/idx/live got %b/%0d/%0d/%b expected %b/%0d/%0d/%b",
                 t, hcnt, vcnt, a[7], a[6:4], a[3:1], a[0], e[7], e[6:4], e[3:1], e[0]);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: outputs held at zero during reset with an image pixel on the counters
    hcnt = 10'd110; vcnt = 9'd20;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if ({ovl_active, src_sel, win_idx, live} !== 8'd0) begin
      errors++;
      $display("FAIL R9 reset outputs got %b expected 00000000", {ovl_active, src_sel, win_idx, live});
    end
    rst_n = 1'b1;
    // R9: single-cycle latency via scoreboard alignment; R1 R3 R8 geometry
    drive(110, 20, "R9");
    drive(0, 0, "R9");
    probe("R1");
    sweep("R1");
    // R3 R5 R6 R7 R8: sparse mask, transparent frame, blank, fill, live
    cfg(0, 20, 4, 4'b0101, 4'b0100, 3'b010, 2'b10, 2'd2);
    probe("R5");
    cfg(0, 20, 4, 4'b0101, 4'b0000, 3'b100, 2'b01, 2'd0);
    probe("R7");
    cfg(0, 20, 4, 4'b1010, 4'b1010, 3'b111, 2'b11, 2'd3);
    probe("R6");
    cfg(0, 20, 4, 4'b0000, 4'b1111, 3'b000, 2'b00, 2'd0);
    probe("R3");
    // R4: large mode, fourth bits and live code 3 address the third slot
    cfg(1, 5, 5, 4'b1000, 4'b1000, 3'b001, 2'b00, 2'd3);
    probe("R4");
    cfg(1, 5, 5, 4'b1011, 4'b0000, 3'b101, 2'b00, 2'd3);
    probe("R4");
    sweep("R4");
    // R2: clamped positions and pixels in the sync interval
    cfg(1, 63, 63, 4'b0111, 4'b0000, 3'b110, 2'b11, 2'd1);
    probe("R2");
    cfg(0, 63, 63, 4'b1111, 4'b0000, 3'b011, 2'b00, 2'd3);
    probe("R2");
    sweep("R2");
    drive(HA - 1, VA - 1, "R2");
    drive(HA, VA - 1, "R2");
    drive(700, 100, "R2");
    drive(1000, 200, "R2");
    drive(300, VA, "R2");
    drive(300, 400, "R2");
    // R8: live moves with live_sel
    cfg(0, 0, 0, 4'b1111, 4'b0000, 3'b000, 2'b00, 2'd1);
    probe("R8");
    cfg(0, 0, 0, 4'b1101, 4'b0000, 3'b000, 2'b00, 2'd1);
    probe("R8");
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule